// File: doc/BRIEF.md
# Spectral Perturbation Bit-Stream Generator

The block makes new test bit-streams from an existing Walsh spectrum. A host supplies N signed coefficients, a per-coefficient keep mask and a noise level, then pulses start. The block takes a copy of all three. It then visits the coefficients in index order. Each coefficient whose mask bit is set passes unchanged. Each of the others receives a signed pseudo-random offset whose size grows with the noise level. The perturbed spectrum goes through an in-place fast Walsh-Hadamard butterfly network, one stage per cycle. The sign of each result becomes one output bit, and the N bits leave serially.

The pseudo-random source keeps running across runs. A sequence of start pulses with the same spectrum therefore gives streams that share every kept component and differ only in the perturbed part. Between runs the host can raise the level to widen the perturbation step by step. At level zero the stream is the sign pattern of the original spectrum.

Top module: `spectral_perturb_gen`

## Requirements
- R1: While reset is held and after it is released, busy_o, valid_o, last_o and bit_o are all 0.
- R2: A start pulse seen while the block is idle begins a run, and busy_o is 1 on the following cycle. A start pulse seen while busy_o is 1 is ignored and produces no further stream.
- R3: Every run emits exactly N bits with valid_o high on N consecutive cycles. last_o is high only with the Nth bit, and valid_o is low on the cycle after it.
- R4: Bits leave in descending index order: transform result N-1 first, result 0 last.
- R5: Output bit i is 1 only when y_i = sum over j of H[i][j]*p_j is strictly greater than zero, with H[i][j] = -1 when popcount(i AND j) is odd and +1 otherwise. A zero sum gives 0.
- R6: A coefficient whose keep bit is 1 enters the sum unchanged, so with every keep bit set the stream is the sign pattern of the input spectrum at any level.
- R7: Level 0 adds nothing to any coefficient, so the stream equals the sign pattern of the input spectrum whatever the mask.
- R8: Noise comes from a 16-bit Galois register that shifts right and XORs 0xB400 when the bit shifted out is 1, with 0xACE1 as its state after reset. Coefficient k (k = 0..N-1 in order) uses the current state before a single step. The magnitude is state[15:1] shifted right by (15 - level), and the value is negated when state[0] is 1. The offset is added to p_k only when keep bit k is 0.
- R9: The register is not reseeded between runs, so each run continues from where the previous run left it (N steps per run).
- R10: Coefficients, mask and level are captured in the cycle that start is taken. Changes to them while busy have no effect on the stream.
- R11: The first valid bit is visible after the (N + log2 N + 2)-th rising edge, counting the edge that samples start as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a run when idle |
| coef_i | input | N*CW | Coefficient k in bits [k*CW +: CW], signed |
| keep_i | input | N | Bit k set keeps coefficient k unperturbed |
| level_i | input | 4 | Noise level 0..15 |
| busy_o | output | 1 | Run in progress |
| bit_o | output | 1 | Serial output bit |
| valid_o | output | 1 | bit_o carries a stream bit |
| last_o | output | 1 | Final bit of the stream |

## Verification
The bound checker watches the stream framing on every cycle: a start taken from idle raises busy, last appears only with valid and only after exactly N-1 earlier contiguous valid cycles, and the line falls quiet after last. The stream contents can only be judged by the bench's scenarios, because the expected bits come from an arithmetic model of the noise register and the Hadamard sum. These scenarios cover every level against several masks, order of emission, zero sums, persistence of the noise state across runs, and inputs that are disturbed during a run.

// File: rtl/spg_pkg.sv
package spg_pkg;
    localparam int LW  = 16;
    localparam int NW  = LW - 1;
    localparam int LVW = $clog2(NW + 1);
    localparam logic [LW-1:0] TAPS = 16'hB400;
    localparam logic [LW-1:0] SEED = 16'hACE1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_XFORM = 2'd2,
        ST_EMIT  = 2'd3
    } spg_state_e;
endpackage

// File: rtl/spg_lfsr_noise.sv
module spg_lfsr_noise
    import spg_pkg::*;
(
    input  logic [LW-1:0]    state_i,
    input  logic [LVW-1:0]   level_i,
    output logic [LW-1:0]    next_o,
    output logic signed [NW:0] noise_o
);
    logic [LVW-1:0] shift;
    logic [NW-1:0]  mag;
    logic signed [NW:0] mag_s;

    always_comb begin
        shift  = LVW'(NW) - level_i;
        mag    = state_i[LW-1:1] >> shift;
        mag_s  = $signed({1'b0, mag});
        noise_o = state_i[0] ? -mag_s : mag_s;
        next_o = state_i[0] ? ((state_i >> 1) ^ TAPS) : (state_i >> 1);
    end
endmodule

// File: rtl/spg_noise_mix.sv
module spg_noise_mix #(
    parameter int AW = 22,
    parameter int NW = 15
) (
    input  logic [AW-1:0]      coef_i,
    input  logic signed [NW:0] noise_i,
    input  logic               keep_i,
    output logic [AW-1:0]      coef_o
);
    logic [AW-1:0] ext;

    always_comb begin
        ext    = AW'(noise_i);
        coef_o = keep_i ? coef_i : (coef_i + ext);
    end
endmodule

// File: rtl/spg_wht_stage.sv
module spg_wht_stage #(
    parameter int N  = 8,
    parameter int AW = 22,
    parameter int H  = 1
) (
    input  logic [N-1:0][AW-1:0] vec_i,
    output logic [N-1:0][AW-1:0] vec_o
);
    for (genvar i = 0; i < N; i++) begin : g_pair
        if (((i / H) % 2) == 0) begin : g_top
            assign vec_o[i]     = vec_i[i] + vec_i[i+H];
            assign vec_o[i+H]   = vec_i[i] - vec_i[i+H];
        end
    end
endmodule

// File: rtl/spectral_perturb_gen.sv
module spectral_perturb_gen
    import spg_pkg::*;
#(
    parameter int N  = 8,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [N*CW-1:0]   coef_i,
    input  logic [N-1:0]      keep_i,
    input  logic [LVW-1:0]    level_i,
    output logic              busy_o,
    output logic              bit_o,
    output logic              valid_o,
    output logic              last_o
);
    localparam int LOG2N = $clog2(N);
    localparam int IW    = LOG2N;
    localparam int PW    = ((CW > NW + 1) ? CW : NW + 1) + 1;
    localparam int AW    = PW + LOG2N;
    localparam int SW    = (LOG2N > 1) ? $clog2(LOG2N) : 1;

    typedef struct packed {
        spg_state_e           st;
        logic [IW-1:0]        idx;
        logic [SW-1:0]        stage;
        logic [N-1:0][AW-1:0] arr;
        logic [N-1:0]         keep;
        logic [LVW-1:0]       lvl;
        logic [LW-1:0]        lfsr;
        logic                 bit_out;
        logic                 valid;
        logic                 last;
    } regs_t;

    regs_t q, d;

    logic [LW-1:0]           lfsr_nxt;
    logic signed [NW:0]      noise;
    logic [AW-1:0]           mixed;
    logic [LOG2N-1:0][N-1:0][AW-1:0] stage_out;

    spg_lfsr_noise u_noise (
        .state_i (q.lfsr),
        .level_i (q.lvl),
        .next_o  (lfsr_nxt),
        .noise_o (noise)
    );

    spg_noise_mix #(.AW(AW), .NW(NW)) u_mix (
        .coef_i  (q.arr[q.idx]),
        .noise_i (noise),
        .keep_i  (q.keep[q.idx]),
        .coef_o  (mixed)
    );

    for (genvar s = 0; s < LOG2N; s++) begin : g_stage
        spg_wht_stage #(.N(N), .AW(AW), .H(1 << s)) u_stage (
            .vec_i (q.arr),
            .vec_o (stage_out[s])
        );
    end

    always_comb begin
        d         = q;
        d.bit_out = 1'b0;
        d.valid   = 1'b0;
        d.last    = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    for (int i = 0; i < N; i++) begin
                        d.arr[i] = AW'($signed(coef_i[i*CW +: CW]));
                    end
                    d.keep = keep_i;
                    d.lvl  = level_i;
                    d.idx  = '0;
                    d.st   = ST_LOAD;
                end
            end
            ST_LOAD: begin
                d.arr[q.idx] = mixed;
                d.lfsr       = lfsr_nxt;
                d.idx        = q.idx + 1'b1;
                if (q.idx == IW'(N - 1)) begin
                    d.stage = '0;
                    d.st    = ST_XFORM;
                end
            end
            ST_XFORM: begin
                d.arr   = stage_out[q.stage];
                d.stage = q.stage + 1'b1;
                if (q.stage == SW'(LOG2N - 1)) begin
                    d.idx = IW'(N - 1);
                    d.st  = ST_EMIT;
                end
            end
            ST_EMIT: begin
                d.bit_out = ($signed(q.arr[q.idx]) > 0);
                d.valid   = 1'b1;
                d.last    = (q.idx == '0);
                d.idx     = q.idx - 1'b1;
                if (q.idx == '0) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.lfsr <= SEED;
        end else begin
            q <= d;
        end
    end

    assign busy_o  = (q.st != ST_IDLE);
    assign bit_o   = q.bit_out;
    assign valid_o = q.valid;
    assign last_o  = q.last;
endmodule

// File: rtl/spg_checker.sv
module spg_checker #(
    parameter int N = 8
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic valid_o,
    input logic last_o
);
    localparam int CNW = $clog2(N) + 1;
    logic [CNW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) run_cnt <= '0;
        else        run_cnt <= valid_o ? run_cnt + 1'b1 : '0;
    end

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R2
    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o); // R3
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> (run_cnt == CNW'(N - 1))); // R3
    AST_RUN_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> valid_o); // R3
    AST_QUIET_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !valid_o); // R3
    AST_MID_RUN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |-> busy_o); // R3
    AST_NO_OVERLONG_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (run_cnt < CNW'(N))); // R3
endmodule

bind spectral_perturb_gen spg_checker #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .valid_o (valid_o),
    .last_o  (last_o)
);

// File: tb/spectral_perturb_gen_bench.sv
module spectral_perturb_gen_bench;
    localparam int N     = 8;
    localparam int CW    = 16;
    localparam int LOG2N = 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            start_i;
    logic [N*CW-1:0] coef_i;
    logic [N-1:0]    keep_i;
    logic [3:0]      level_i;
    logic            busy_o, bit_o, valid_o, last_o;

    always #5 clk = ~clk;

    spectral_perturb_gen #(.N(N), .CW(CW)) u_spectral_perturb_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .coef_i(coef_i),
        .keep_i(keep_i), .level_i(level_i), .busy_o(busy_o), .bit_o(bit_o),
        .valid_o(valid_o), .last_o(last_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] lf_m;
    int cf[N];
    logic [N-1:0] mk;
    int lv;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // model of one run; advances the noise register N steps
    task automatic model_run(output logic [N-1:0] e);
        int p[N];
        for (int k = 0; k < N; k++) begin
            int mag, nz;
            mag = int'(lf_m[15:1]) >> (15 - lv);
            nz  = lf_m[0] ? -mag : mag;
            p[k] = cf[k] + (mk[k] ? 0 : nz);
            lf_m = lf_m[0] ? ((lf_m >> 1) ^ 16'hB400) : (lf_m >> 1);
        end
        for (int i = 0; i < N; i++) begin
            longint s = 0;
            for (int j = 0; j < N; j++) begin
                if (($countones(i & j) % 2) == 1) s -= p[j];
                else                              s += p[j];
            end
            e[i] = (s > 0);
        end
    endtask

    task automatic run(input bit disturb, output logic [N-1:0] got, output int lat);
        int vbad = 0;
        int lbad = 0;
        @(negedge clk);
        for (int k = 0; k < N; k++) coef_i[k*CW +: CW] = 16'(cf[k]);
        keep_i  = mk;
        level_i = 4'(lv);
        start_i = 1'b1;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start_i = 1'b0;
        while (!valid_o && lat < 100) begin
            if (disturb && lat == 2) begin
                start_i = 1'b1;
                coef_i  = ~coef_i;
                keep_i  = ~keep_i;
                level_i = ~level_i;
            end
            if (lat == 4) start_i = 1'b0;
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        start_i = 1'b0;
        check(valid_o, "R3", "stream began", valid_o, 1);
        for (int k = 0; k < N; k++) begin
            got[N-1-k] = bit_o;
            if (!valid_o) vbad++;
            if (last_o != (k == N - 1)) lbad++;
            if (k < N - 1) begin
                @(posedge clk);
                @(negedge clk);
            end
        end
        check(vbad == 0, "R3", "valid gaps", vbad, 0);
        check(lbad == 0, "R3", "last placement", lbad, 0);
        @(posedge clk);
        @(negedge clk);
        check(!valid_o, "R3", "valid after last", valid_o, 0);
    endtask

    task automatic rand_coefs(input int span);
        for (int k = 0; k < N; k++) cf[k] = int'($urandom_range(2 * span)) - span;
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [N-1:0] got, exp, got2, exp2;
        int lat;
        logic [N-1:0] masks[4];
        masks = '{8'h00, 8'hAA, 8'h0F, 8'h81};
        lf_m = 16'hACE1;
        rst_n = 1'b0; start_i = 1'b0; coef_i = '0; keep_i = '0; level_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy_o && !valid_o && !last_o && !bit_o, "R1", "outputs in reset",
              {busy_o, valid_o, last_o, bit_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(!busy_o && !valid_o && !last_o && !bit_o, "R1", "outputs after reset",
              {busy_o, valid_o, last_o, bit_o}, 0);

        // R11 and R7: level 0, nothing kept
        rand_coefs(3000); mk = '0; lv = 0;
        model_run(exp);
        run(1'b0, got, lat);
        check(lat == N + LOG2N + 2, "R11", "first-bit latency", lat, N + LOG2N + 2);
        check(got == exp, "R7", "level 0 sign pattern", got, exp);

        // R4: only DC=10 and w1=-20 -> odd indices positive
        cf = '{10, -20, 0, 0, 0, 0, 0, 0}; mk = '0; lv = 0;
        model_run(exp);
        run(1'b0, got, lat);
        check(got == 8'hAA, "R4", "emission order", got, 8'hAA);

        // R5: all-zero spectrum sums to zero -> all bits 0
        cf = '{0, 0, 0, 0, 0, 0, 0, 0}; mk = '1; lv = 9;
        model_run(exp);
        run(1'b0, got, lat);
        check(got == '0, "R5", "zero sums give 0", got, 0);

        // R6: everything kept, full level
        rand_coefs(3000); mk = '1; lv = 15;
        model_run(exp);
        run(1'b0, got, lat);
        check(got == exp, "R6", "kept spectrum at level 15", got, exp);

        // R8 and R5: every level against several masks
        for (int l = 0; l < 16; l++) begin
            for (int m = 0; m < 4; m++) begin
                rand_coefs(2000); mk = masks[m]; lv = l;
                model_run(exp);
                run(1'b0, got, lat);
                check(got == exp, "R8", $sformatf("level %0d mask %0h", l, masks[m]), got, exp);
            end
        end

        // R9: same spectrum twice continues the noise sequence
        rand_coefs(500); mk = '0; lv = 15;
        model_run(exp);
        run(1'b0, got, lat);
        check(got == exp, "R9", "first repeat run", got, exp);
        model_run(exp2);
        run(1'b0, got2, lat);
        check(got2 == exp2, "R9", "second repeat run", got2, exp2);

        // R10 and R2: inputs and start disturbed while busy
        rand_coefs(2500); mk = 8'h3C; lv = 6;
        model_run(exp);
        run(1'b1, got, lat);
        check(got == exp, "R10", "capture at start", got, exp);
        begin
            int extra = 0;
            repeat (30) begin
                @(posedge clk);
                @(negedge clk);
                if (valid_o || busy_o) extra++;
            end
            check(extra == 0, "R2", "no stream from busy start", extra, 0);
        end
        rand_coefs(2500); mk = 8'h00; lv = 12;
        model_run(exp);
        run(1'b0, got, lat);
        check(got == exp, "R2", "noise state untouched by ignored start", got, exp);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule